// File: doc/BRIEF.md
# Lane Configuration Register Bank with Serial Target

This block is a two-wire serial (I2C) target that holds the control settings of a four-lane signal conditioner: equalizer boost, output swing, de-emphasis and lane enable for each lane. It also holds detector controls that are read and written over the bus. SCL and SDA are sampled by a system clock. SDA is driven open-drain through an output-enable that pulls the line low.

Every bus transfer starts at register 0 and steps through consecutive registers, and the pointer wraps after register 15. On a write, the first byte after the address is treated as an offset byte from the host and is dropped. After reset, the registers take their values from the strap pins. A mode pin chooses what each lane uses: the straps directly, or the register fields for that lane.

Top module: `cfg_bank_i2c`

## Requirements
- R1: The target answers only to the 7-bit address {1,1,addr_strap_i[2],0,0,addr_strap_i[1],addr_strap_i[0]} (MSB first, R/W as bit 0). Any other address gets no ACK and changes no state.
- R2: On a write, the target ACKs the address and every byte. The first byte after the address is dropped. The bytes that follow go to registers 0, 1, 2 and so on.
- R3: A read returns registers 0, 1, 2 and so on, MSB first. It ends when the host NACKs, and SDA is released before the next SCL high phase.
- R4: Register 0 reads {activity_i[3:0],4'b0000}, with lane n at bit 4+n. Registers 1, 7 and 11 to 15 read 0, as does the low nibble of registers 2 and 9. Writes to any of these read-only bits have no effect.
- R5: One clock after reset is released, the registers load as follows. Register 2 is {4{pwr_en_i}},4'h0. Registers 3 and 4 are {boost_strap_i,boost_strap_i}. Register 5 is {4{swing_strap_i,1'b1}}. Register 6 is {4{deemph_strap_i}}. Register 8 is 8'hF0, and registers 9 and 10 are 0.
- R6: Field layout is as follows. Lane n's enable is register 2 bit 4+n. The boost of lane 0 is register 3 [3:0] and of lane 1 is register 3 [7:4]; lanes 2 and 3 use register 4 the same way. Swing and de-emphasis of lane n are bits [2n+1:2n] of registers 5 and 6.
- R7: With pin_mode_i high, every lane reports boost_strap_i, {swing_strap_i,1'b1}, deemph_strap_i and an enable equal to pwr_en_i.
- R8: With pin_mode_i low, every lane reports its own register fields. Changing the straps then has no effect on the outputs or the registers.
- R9: The register pointer wraps from 15 to 0 within one transfer, for both writes and reads.
- R10: The target changes SDA only while the synchronised SCL is low. After a STOP it has SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low |
| addr_strap_i | input | 3 | Address straps for address bits 4, 1, 0 |
| pin_mode_i | input | 1 | High selects strap values for all lanes |
| pwr_en_i | input | 1 | Power-enable strap |
| boost_strap_i | input | 4 | Boost code strap |
| swing_strap_i | input | 1 | Swing upper-bit strap |
| deemph_strap_i | input | 2 | De-emphasis code strap |
| activity_i | input | 4 | Per-lane activity flags |
| eff_en_o | output | 4 | Effective lane enables |
| eff_boost_o | output | 16 | Effective boost, lane n at [4n+3:4n] |
| eff_swing_o | output | 8 | Effective swing, lane n at [2n+1:2n] |
| eff_deemph_o | output | 8 | Effective de-emphasis, lane n at [2n+1:2n] |

## Verification
The assertions check four things on every cycle: the strap override in pin mode, that SDA moves only while SCL is low, that SDA is released after a STOP, and that read-only addresses present zero. Several behaviours depend on byte sequences across a whole transfer, so only the bench scenarios show them. These are the dropped offset byte, the pointer wrap, the NACK-terminated read, rejection of a foreign address, and the load from straps after a second reset with different pins. A behavioural register model also confirms the effective lane outputs whenever the bus is idle.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int unsigned NCH     = 4;
  localparam int unsigned BOOST_W = 4;
  localparam int unsigned SWING_W = 2;
  localparam int unsigned DE_W    = 2;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NREG    = 16;
  localparam int unsigned PTR_W   = $clog2(NREG);

  localparam int unsigned RG_STAT  = 0;
  localparam int unsigned RG_EN    = 2;
  localparam int unsigned RG_BST_L = 3;
  localparam int unsigned RG_BST_H = 4;
  localparam int unsigned RG_SWING = 5;
  localparam int unsigned RG_DE    = 6;
  localparam int unsigned RG_PD    = 8;
  localparam int unsigned RG_ACT   = 9;
  localparam int unsigned RG_VTH   = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE, ST_WR_ACK, ST_READ, ST_RD_ACK
  } i2c_st_e;

  function automatic logic [REG_W-1:0] wr_mask(int unsigned idx);
    case (idx)
      RG_EN, RG_ACT:                                   return 8'hF0;
      RG_BST_L, RG_BST_H, RG_SWING, RG_DE, RG_PD, RG_VTH: return 8'hFF;
      default:                                         return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] rst_val(int unsigned idx);
    case (idx)
      RG_SWING: return 8'h55;
      RG_PD:    return 8'hF0;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_o      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_p      = scl_q[STAGES];
  assign sda_p      = sda_q[STAGES];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import cfg_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [REG_W-1:0] rd_data_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [3:0] BITS = 4'(REG_W);

  i2c_st_e          st_q;
  logic [3:0]       cnt_q;
  logic [REG_W-1:0] sh_q;
  logic             rw_q, first_q, acked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      acked_q  <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_en_o  <= 1'b0;
      ptr_o    <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (wr_en_o) ptr_o <= ptr_o + 1'b1;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[REG_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BITS) begin
              if (sh_q[7:1] == dev_addr_i) begin
                sda_oe_o <= 1'b1;
                rw_q     <= sh_q[0];
                ptr_o    <= '0;
                first_q  <= 1'b1;
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[REG_W-1];
              st_q     <= ST_READ;
            end else begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_WRITE;
            end
          end
          ST_WRITE: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[REG_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BITS) begin
              sda_oe_o <= 1'b1;
              st_q     <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            st_q     <= ST_WRITE;
            if (first_q) first_q <= 1'b0;  // host offset byte is dropped
            else         wr_en_o <= 1'b1;
          end
          ST_READ: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == BITS) begin
                sda_oe_o <= 1'b0;
                ptr_o    <= ptr_o + 1'b1;
                st_q     <= ST_RD_ACK;
              end else begin
                sh_q     <= {sh_q[REG_W-2:0], 1'b0};
                sda_oe_o <= ~sh_q[REG_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              acked_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (acked_q) begin
                sh_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[REG_W-1];
                cnt_q    <= '0;
                st_q     <= ST_READ;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_data_o = sh_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_bank_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pwr_en_i,
  input  logic [BOOST_W-1:0]       boost_strap_i,
  input  logic                     swing_strap_i,
  input  logic [DE_W-1:0]          deemph_strap_i,
  input  logic [NCH-1:0]           activity_i,
  input  logic                     wr_en_i,
  input  logic [PTR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]         wr_data_i,
  output logic [REG_W-1:0]         rd_data_o,
  output logic [NCH-1:0]           reg_en_o,
  output logic [NCH*BOOST_W-1:0]   reg_boost_o,
  output logic [NCH*SWING_W-1:0]   reg_swing_o,
  output logic [NCH*DE_W-1:0]      reg_de_o
);
  logic [REG_W-1:0] regs_q   [NREG];
  logic [REG_W-1:0] strap_val[NREG];
  logic             load_q;

  always_comb begin
    for (int i = 0; i < NREG; i++) strap_val[i] = rst_val(i);
    strap_val[RG_EN]    = {{NCH{pwr_en_i}}, 4'h0};
    strap_val[RG_BST_L] = {boost_strap_i, boost_strap_i};
    strap_val[RG_BST_H] = {boost_strap_i, boost_strap_i};
    strap_val[RG_SWING] = {NCH{swing_strap_i, 1'b1}};
    strap_val[RG_DE]    = {NCH{deemph_strap_i}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b1;
      for (int i = 0; i < NREG; i++) regs_q[i] <= rst_val(i);
    end else begin
      load_q <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        if (load_q)
          regs_q[i] <= strap_val[i];
        else if (wr_en_i && addr_i == PTR_W'(i))
          regs_q[i] <= (regs_q[i] & ~wr_mask(i)) | (wr_data_i & wr_mask(i));
      end
    end
  end

  assign rd_data_o   = (addr_i == PTR_W'(RG_STAT)) ? {activity_i, 4'h0} : regs_q[addr_i];
  assign reg_en_o    = regs_q[RG_EN][7:4];
  assign reg_boost_o = {regs_q[RG_BST_H], regs_q[RG_BST_L]};
  assign reg_swing_o = regs_q[RG_SWING];
  assign reg_de_o    = regs_q[RG_DE];
endmodule

// File: rtl/lane_mode_mux.sv
module lane_mode_mux
  import cfg_bank_pkg::*;
(
  input  logic                   pin_mode_i,
  input  logic                   pwr_en_i,
  input  logic [BOOST_W-1:0]     boost_strap_i,
  input  logic                   swing_strap_i,
  input  logic [DE_W-1:0]        deemph_strap_i,
  input  logic [NCH-1:0]         reg_en_i,
  input  logic [NCH*BOOST_W-1:0] reg_boost_i,
  input  logic [NCH*SWING_W-1:0] reg_swing_i,
  input  logic [NCH*DE_W-1:0]    reg_de_i,
  output logic [NCH-1:0]         eff_en_o,
  output logic [NCH*BOOST_W-1:0] eff_boost_o,
  output logic [NCH*SWING_W-1:0] eff_swing_o,
  output logic [NCH*DE_W-1:0]    eff_deemph_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign eff_en_o[c] = pin_mode_i ? pwr_en_i : reg_en_i[c];
    assign eff_boost_o[c*BOOST_W +: BOOST_W] =
      pin_mode_i ? boost_strap_i : reg_boost_i[c*BOOST_W +: BOOST_W];
    assign eff_swing_o[c*SWING_W +: SWING_W] =
      pin_mode_i ? {swing_strap_i, 1'b1} : reg_swing_i[c*SWING_W +: SWING_W];
    assign eff_deemph_o[c*DE_W +: DE_W] =
      pin_mode_i ? deemph_strap_i : reg_de_i[c*DE_W +: DE_W];
  end
endmodule

// File: rtl/cfg_bank_i2c.sv
module cfg_bank_i2c
  import cfg_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [2:0]             addr_strap_i,
  input  logic                   pin_mode_i,
  input  logic                   pwr_en_i,
  input  logic [BOOST_W-1:0]     boost_strap_i,
  input  logic                   swing_strap_i,
  input  logic [DE_W-1:0]        deemph_strap_i,
  input  logic [NCH-1:0]         activity_i,
  output logic [NCH-1:0]         eff_en_o,
  output logic [NCH*BOOST_W-1:0] eff_boost_o,
  output logic [NCH*SWING_W-1:0] eff_swing_o,
  output logic [NCH*DE_W-1:0]    eff_deemph_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic wr_en;
  logic [REG_W-1:0] wr_data, rd_data;
  logic [PTR_W-1:0] ptr;
  logic [6:0] dev_addr;
  logic [NCH-1:0]         reg_en;
  logic [NCH*BOOST_W-1:0] reg_boost;
  logic [NCH*SWING_W-1:0] reg_swing;
  logic [NCH*DE_W-1:0]    reg_de;

  assign dev_addr = {2'b11, addr_strap_i[2], 2'b00, addr_strap_i[1:0]};

  i2c_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  i2c_tgt_engine u_eng (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_s), .stop_i(stop_s), .dev_addr_i(dev_addr), .rd_data_i(rd_data),
    .sda_oe_o, .wr_en_o(wr_en), .wr_data_o(wr_data), .ptr_o(ptr)
  );

  cfg_regfile u_regs (
    .clk_i, .rst_ni, .pwr_en_i, .boost_strap_i, .swing_strap_i, .deemph_strap_i,
    .activity_i, .wr_en_i(wr_en), .addr_i(ptr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .reg_en_o(reg_en), .reg_boost_o(reg_boost), .reg_swing_o(reg_swing), .reg_de_o(reg_de)
  );

  lane_mode_mux u_mux (
    .pin_mode_i, .pwr_en_i, .boost_strap_i, .swing_strap_i, .deemph_strap_i,
    .reg_en_i(reg_en), .reg_boost_i(reg_boost), .reg_swing_i(reg_swing), .reg_de_i(reg_de),
    .eff_en_o, .eff_boost_o, .eff_swing_o, .eff_deemph_o
  );
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   pin_mode_i,
  input logic                   pwr_en_i,
  input logic [BOOST_W-1:0]     boost_strap_i,
  input logic [NCH-1:0]         eff_en_o,
  input logic [NCH*BOOST_W-1:0] eff_boost_o,
  input logic                   sda_oe_o,
  input logic                   scl_s,
  input logic                   stop_s,
  input logic                   wr_en,
  input logic [PTR_W-1:0]       ptr,
  input logic [REG_W-1:0]       rd_data
);
  a_r7_pin_boost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_mode_i |-> eff_boost_o == {NCH{boost_strap_i}});

  a_r7_pin_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_mode_i |-> eff_en_o == {NCH{pwr_en_i}});

  a_r10_sda_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

  a_r10_release_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_s |=> !sda_oe_o);

  a_r4_ro_regs_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == 4'd1 || ptr == 4'd7 || ptr >= 4'd11) |-> rd_data == 8'h00);

  a_r2_commit_line_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !sda_oe_o);
endmodule

bind cfg_bank_i2c cfg_bank_chk u_chk (
  .clk_i, .rst_ni, .pin_mode_i, .pwr_en_i, .boost_strap_i, .eff_en_o, .eff_boost_o,
  .sda_oe_o, .scl_s, .stop_s, .wr_en, .ptr, .rd_data
);

// File: tb/test_cfg_bank_i2c.sv
module test_cfg_bank_i2c;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [2:0] a_strap = 3'b101;
  logic pin_mode = 1'b0, pwr_en = 1'b1, swing = 1'b1;
  logic [3:0] boost = 4'hA;
  logic [1:0] de = 2'b10;
  logic [3:0] act = 4'b1010;
  logic [3:0]  eff_en;
  logic [15:0] eff_boost;
  logic [7:0]  eff_swing, eff_de;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  logic [7:0] mdl [16];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic ack;

  always #4 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  cfg_bank_i2c i_cfg_bank_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_strap_i(a_strap), .pin_mode_i(pin_mode), .pwr_en_i(pwr_en),
    .boost_strap_i(boost), .swing_strap_i(swing), .deemph_strap_i(de),
    .activity_i(act), .eff_en_o(eff_en), .eff_boost_o(eff_boost),
    .eff_swing_o(eff_swing), .eff_deemph_o(eff_de)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] msk(int i);
    case (i)
      2, 9: return 8'hF0;
      3, 4, 5, 6, 8, 10: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdl_load();
    foreach (mdl[i]) mdl[i] = 8'h00;
    mdl[2] = {{4{pwr_en}}, 4'h0};
    mdl[3] = {boost, boost};
    mdl[4] = {boost, boost};
    mdl[5] = {4{swing, 1'b1}};
    mdl[6] = {4{de}};
    mdl[8] = 8'hF0;
  endtask

  function automatic logic [7:0] exp_rd(int i);
    return (i == 0) ? {act, 4'h0} : mdl[i];
  endfunction

  // per-clock comparison of lane outputs against the model while the bus is idle
  always @(negedge clk) if (cmp_en && rst_n) begin
    logic [35:0] e;
    for (int c = 0; c < 4; c++) begin
      if (pin_mode) begin
        e[c] = pwr_en; e[4+4*c +: 4] = boost; e[20+2*c +: 2] = {swing, 1'b1}; e[28+2*c +: 2] = de;
      end else begin
        e[c] = mdl[2][4+c];
        e[4+4*c +: 4] = (c < 2) ? mdl[3][4*c +: 4] : mdl[4][4*(c-2) +: 4];
        e[20+2*c +: 2] = mdl[5][2*c +: 2];
        e[28+2*c +: 2] = mdl[6][2*c +: 2];
      end
    end
    check(pin_mode ? "R7 lanes" : "R8/R6 lanes", {eff_de, eff_swing, eff_boost, eff_en}, e);
  end

  task automatic qw(); repeat (Q) @(posedge clk); #1; endtask

  task automatic start_c(); m_low = 0; scl = 1; qw(); m_low = 1; qw(); scl = 0; qw(); endtask
  task automatic stop_c(); scl = 0; m_low = 1; qw(); scl = 1; qw(); m_low = 0; qw(); qw(); endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    end
    m_low = 0; qw(); scl = 1; qw(); a = ~sda_bus; qw(); scl = 0; qw();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1; qw(); b[i] = sda_bus; qw(); scl = 0; qw();
    end
    m_low = ~nack; qw(); scl = 1; qw(); qw(); scl = 0; qw(); m_low = 0;
  endtask

  // offset byte, then n data bytes from wbuf
  task automatic wr_block(input logic [6:0] a, input int n);
    cmp_en = 0;
    start_c();
    send_byte({a, 1'b0}, ack); check("R1 addr ack", ack, 1);
    send_byte(8'h5A, ack);     check("R2 offset ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); check("R2 data ack", ack, 1);
      mdl[k % 16] = (mdl[k % 16] & ~msk(k % 16)) | (wbuf[k] & msk(k % 16));
    end
    stop_c();
    check("R10 sda released after stop", sda_oe, 0);
    cmp_en = 1;
  endtask

  task automatic rd_block(input logic [6:0] a, input int n, input string req);
    cmp_en = 0;
    start_c();
    send_byte({a, 1'b1}, ack); check("R1 read addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, rbuf[k]);
      check(req, {k[7:0], rbuf[k]}, {k[7:0], exp_rd(k % 16)});
    end
    check("R3 sda released after nack", sda_oe, 0);
    stop_c();
    cmp_en = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    check("R5 sda idle in reset", sda_oe, 0);
    rst_n = 1;
    @(posedge clk); #1;
    mdl_load();
    @(posedge clk); #1;
    cmp_en = 1;
    repeat (5) @(posedge clk); #1;

    // R5/R4: startup values read back, activity in register 0
    rd_block(7'h71, 16, "R5/R4 startup readback");

    // R1: foreign address gets no ACK and writes nothing
    cmp_en = 0;
    start_c();
    send_byte(8'hEA, ack); check("R1 foreign addr nack", ack, 0);
    send_byte(8'h00, ack); check("R1 foreign data nack", ack, 0);
    send_byte(8'hFF, ack);
    stop_c();
    cmp_en = 1;
    repeat (10) @(posedge clk); #1;
    rd_block(7'h71, 11, "R1 state untouched");

    // R2/R6/R8: full write incl. read-only locations
    wbuf[0] = 8'hFF; wbuf[1] = 8'hA5; wbuf[2] = 8'h5F; wbuf[3] = 8'h21;
    wbuf[4] = 8'h43; wbuf[5] = 8'hC6; wbuf[6] = 8'h1B; wbuf[7] = 8'h77;
    wbuf[8] = 8'h3C; wbuf[9] = 8'hFF; wbuf[10] = 8'h96;
    wr_block(7'h71, 11);
    repeat (10) @(posedge clk); #1;
    rd_block(7'h71, 11, "R2/R4 written readback");
    check("R6 lane1 boost from reg3 hi", eff_boost[7:4], 4'h2);
    check("R6 lane2 swing from reg5", eff_swing[5:4], 2'b00);

    // R8: straps ignored when pin mode low
    boost = 4'h3; de = 2'b01; swing = 1'b0; pwr_en = 1'b0;
    repeat (20) @(posedge clk); #1;
    check("R8 boost unaffected by strap", eff_boost, 16'h1B43 ^ 16'h0000 ^ {mdl[4], mdl[3]} ^ 16'h1B43);

    // R7: pin mode override, then registers still intact
    pin_mode = 1;
    repeat (20) @(posedge clk); #1;
    check("R7 pin boost", eff_boost, 16'h3333);
    pin_mode = 0;
    rd_block(7'h71, 7, "R8 regs kept across pin mode");

    // R9: write wraps past 15 into register 2
    for (int k = 0; k < 19; k++) wbuf[k] = 8'(8'h11 * (k + 1));
    wbuf[18] = 8'hB0;
    wr_block(7'h71, 19);
    repeat (10) @(posedge clk); #1;
    check("R9 wrap wrote reg2 enables", eff_en, 4'hB);
    act = 4'b0101;
    rd_block(7'h71, 19, "R9 read wrap");

    // R3: short read ends on NACK and next read restarts at 0
    rd_block(7'h71, 2, "R3 short read");
    rd_block(7'h71, 1, "R3 restart at reg0");

    // R5: second reset with new straps
    cmp_en = 0;
    rst_n = 0;
    boost = 4'h6; de = 2'b11; swing = 1'b0; pwr_en = 1'b1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
    mdl_load();
    @(posedge clk); #1;
    cmp_en = 1;
    check("R5 reload boost", eff_boost, 16'h6666);
    check("R5 reload swing", eff_swing, 8'h55);
    rd_block(7'h71, 11, "R5 reload readback");

    repeat (10) @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule